// File: doc/BRIEF.md
# UART FIFO Trigger Controller

This block holds the two byte queues that sit between a UART's host interface and its serial shifters: a transmit queue filled by the host and drained by the transmit shifter, and a receive queue filled by the receive shifter and drained by the host. Each queue holds 16 bytes and has a level counter, full and empty flags, and a registered read port.

An 8-bit control write port sets the queue behaviour. One bit enables the queues. Two self-clearing bits empty either queue. Two 2-bit fields pick the trigger thresholds. The receive request is raised while the receive queue holds at least its threshold. The transmit request follows a two-mode rule. If the queue was filled past its threshold since it was last empty, the request is raised once the level drops below the threshold. Otherwise the request is raised only when the queue runs empty. The transmit threshold field can be written only while an enhanced-feature enable input is high.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: Each queue holds 16 bytes. Its level output counts 0 to 16. Full is 1 exactly at level 16 and empty is 1 exactly at level 0.
- R2: Bytes leave each queue in the order they entered. The byte taken by an accepted pop appears on the read-data output in the cycle after the pop.
- R3: A push into a full queue is dropped and the level stays 16. The matching overflow output is 1 for exactly the one cycle after that push.
- R4: A pop from an empty queue leaves the read-data output unchanged and the level at 0.
- R5: A control write with bit 1 = 1 and bit 0 = 1 sets the receive level to 0 from the next cycle. Bit 1 written with bit 0 = 0 leaves the receive queue as it is. The read-data output is not altered by this clear.
- R6: A control write with bit 2 = 1 and bit 0 = 1 sets the transmit level to 0 from the next cycle. Bit 2 written with bit 0 = 0 leaves the transmit queue as it is.
- R7: The control read-back returns bits 1 and 2 as 0. Bits 0, 3, 7:6 and (when accepted) 5:4 return the last value written to them. Bit 3 has no effect on behaviour.
- R8: Receive threshold field bits 7:6 maps codes 00, 01, 10 and 11 to 1, 4, 8 and 14 bytes. The receive request is 1 exactly while the receive level is at least the threshold.
- R9: Transmit threshold field bits 5:4 uses the same code-to-level map. It is updated by a control write only while the enhanced enable is 1, and otherwise keeps its value.
- R10: The transmit request is 1 whenever the transmit level is 0. If the level has exceeded the transmit threshold since the queue was last empty, the request is also 1 while the level is below the threshold; otherwise it is 0 at any non-zero level.
- R11: After reset both levels are 0, the control read-back is 0x00 (both thresholds 1), the transmit request is 1, and the receive request and both overflow outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| enh_en | input | 1 | Enhanced-feature enable; allows transmit threshold writes |
| ctl_rdata | output | 8 | Control read-back |
| host_push | input | 1 | Host writes a byte into the transmit queue |
| host_wdata | input | 8 | Byte for the transmit queue |
| host_pop | input | 1 | Host takes a byte from the receive queue |
| host_rdata | output | 8 | Last byte taken from the receive queue |
| line_rx_valid | input | 1 | Receive shifter delivers a byte |
| line_rx_data | input | 8 | Byte from the receive shifter |
| line_tx_req | input | 1 | Transmit shifter requests a byte |
| line_tx_data | output | 8 | Last byte handed to the transmit shifter |
| tx_level | output | 5 | Transmit queue fill level |
| rx_level | output | 5 | Receive queue fill level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_ovf | output | 1 | One-cycle pulse: transmit push dropped |
| rx_ovf | output | 1 | One-cycle pulse: receive push dropped |
| tx_irq | output | 1 | Transmit service request |
| rx_irq | output | 1 | Receive service request |

## Verification
A corrupted level counter shows on the level, full and empty outputs in the very next cycle, and on the request outputs in the same cycle. A pointer error stays hidden until the affected entry is popped, so the order checks drain whole fills. A wrong transmit "filled past threshold" flag changes nothing at the ports until the level falls below the threshold. For that reason the transmit request is checked after a shallow fill and again after a deep fill, at the exact crossing level. Threshold decoding is swept over all four codes on both sides of each boundary.

// File: rtl/uft_pkg.sv
package uft_pkg;

  // Threshold code to byte count (shared by both directions)
  function automatic logic [4:0] trig_level(input logic [1:0] code);
    case (code)
      2'b00:   trig_level = 5'd1;
      2'b01:   trig_level = 5'd4;
      2'b10:   trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

  // Next pointer with wrap at depth
  function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
    ptr_next = (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/uft_ctl_reg.sv
module uft_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       enh,
  output logic [7:0] rdata,
  output logic [1:0] rx_code,
  output logic [1:0] tx_code,
  output logic       rx_clr,
  output logic       tx_clr
);
  logic       en_q;
  logic       spare_q;
  logic [1:0] rx_code_q;
  logic [1:0] tx_code_q;

  // Queue clears act in the write cycle only and are never stored
  assign rx_clr = wr & wdata[0] & wdata[1];
  assign tx_clr = wr & wdata[0] & wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      spare_q   <= 1'b0;
      rx_code_q <= 2'b00;
      tx_code_q <= 2'b00;
    end else if (wr) begin
      en_q      <= wdata[0];
      spare_q   <= wdata[3];
      rx_code_q <= wdata[7:6];
      if (enh) tx_code_q <= wdata[5:4];
    end
  end

  assign rx_code = rx_code_q;
  assign tx_code = tx_code_q;
  assign rdata   = {rx_code_q, tx_code_q, spare_q, 2'b00, en_q};

  // R9: transmit threshold is locked while the enhanced enable is low
  a_r9_tx_code_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !enh) |=> $stable(tx_code_q));

endmodule

// File: rtl/uft_byte_fifo.sv
module uft_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty,
  output logic             ovf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    level_q;
  logic [WIDTH-1:0] rdata_q;
  logic             ovf_q;
  logic             push_ok, pop_ok, push_drop;

  assign full      = (level_q == LW'(DEPTH));
  assign empty     = (level_q == '0);
  assign push_ok   = push & ~full & ~clr;
  assign pop_ok    = pop & ~empty & ~clr;
  assign push_drop = push & full & ~clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      rdata_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= push_drop;
      if (clr) begin
        wr_ptr  <= '0;
        rd_ptr  <= '0;
        level_q <= '0;
      end else begin
        if (push_ok) wr_ptr <= AW'(uft_pkg::ptr_next(int'(wr_ptr), DEPTH));
        if (pop_ok) begin
          rd_ptr  <= AW'(uft_pkg::ptr_next(int'(rd_ptr), DEPTH));
          rdata_q <= mem[rd_ptr];
        end
        if (push_ok && !pop_ok)      level_q <= level_q + 1'b1;
        else if (pop_ok && !push_ok) level_q <= level_q - 1'b1;
      end
    end
  end

  assign rdata = rdata_q;
  assign level = level_q;
  assign ovf   = ovf_q;

  // R1: level never exceeds the depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));

  // R3: a push into a full queue is dropped and flagged
  a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (ovf && full));

  // R4: a pop from an empty queue changes nothing
  a_r4_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> ($stable(rdata_q) && empty));

endmodule

// File: rtl/uft_trig_irq.sv
module uft_trig_irq #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic [1:0]    rx_code,
  input  logic [1:0]    tx_code,
  input  logic          tx_clr,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          tx_above
);
  logic [LW-1:0] rx_trig, tx_trig;
  logic          above_q;
  logic          tx_zero;

  assign rx_trig = LW'(uft_pkg::trig_level(rx_code));
  assign tx_trig = LW'(uft_pkg::trig_level(tx_code));
  assign tx_zero = (tx_level == '0);

  // Remembers a fill past the threshold since the last empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       above_q <= 1'b0;
    else if (tx_clr || tx_zero)       above_q <= 1'b0;
    else if (tx_level > tx_trig)      above_q <= 1'b1;
  end

  assign tx_above = above_q;
  assign rx_irq   = (rx_level >= rx_trig);
  assign tx_irq   = above_q ? (tx_level < tx_trig) : tx_zero;

  // R10: an empty transmit queue always requests service
  a_r10_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> tx_irq);

  // R8: an empty receive queue never requests service
  a_r8_rx_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_irq);

endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic             enh_en,
  output logic [7:0]       ctl_rdata,
  input  logic             host_push,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_pop,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             line_rx_valid,
  input  logic [WIDTH-1:0] line_rx_data,
  input  logic             line_tx_req,
  output logic [WIDTH-1:0] line_tx_data,
  output logic [LW-1:0]    tx_level,
  output logic [LW-1:0]    rx_level,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             tx_ovf,
  output logic             rx_ovf,
  output logic             tx_irq,
  output logic             rx_irq
);
  logic [1:0] rx_code, tx_code;
  logic       rx_clr, tx_clr;
  logic       tx_above;

  uft_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctl_wr),
    .wdata   (ctl_wdata),
    .enh     (enh_en),
    .rdata   (ctl_rdata),
    .rx_code (rx_code),
    .tx_code (tx_code),
    .rx_clr  (rx_clr),
    .tx_clr  (tx_clr)
  );

  uft_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tx_clr),
    .push  (host_push),
    .wdata (host_wdata),
    .pop   (line_tx_req),
    .rdata (line_tx_data),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty),
    .ovf   (tx_ovf)
  );

  uft_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .push  (line_rx_valid),
    .wdata (line_rx_data),
    .pop   (host_pop),
    .rdata (host_rdata),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty),
    .ovf   (rx_ovf)
  );

  uft_trig_irq #(.LW(LW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_level (rx_level),
    .tx_level (tx_level),
    .rx_code  (rx_code),
    .tx_code  (tx_code),
    .tx_clr   (tx_clr),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq),
    .tx_above (tx_above)
  );

  // R5: receive clear empties the queue
  a_r5_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_level == '0));

  // R6: transmit clear empties the queue and forgets the deep fill
  a_r6_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> ((tx_level == '0) && !tx_above));

endmodule

// File: tb/uart_fifo_trig_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_trig_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       enh_en = 1'b0;
  logic [7:0] ctl_rdata;
  logic       host_push = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_pop = 1'b0;
  logic [7:0] host_rdata;
  logic       line_rx_valid = 1'b0;
  logic [7:0] line_rx_data = '0;
  logic       line_tx_req = 1'b0;
  logic [7:0] line_tx_data;
  logic [4:0] tx_level, rx_level;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic       tx_ovf, rx_ovf, tx_irq, rx_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_fifo_trig_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .enh_en(enh_en), .ctl_rdata(ctl_rdata), .host_push(host_push),
    .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data),
    .line_tx_req(line_tx_req), .line_tx_data(line_tx_data),
    .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  typedef struct packed {
    logic [1:0] code;
    logic [4:0] n;
    logic       irq;
  } vec_t;

  // Receive threshold sweep: code, bytes pushed, expected request
  localparam vec_t VECS [8] = '{
    '{2'd0, 5'd0,  1'b0}, '{2'd0, 5'd1,  1'b1},
    '{2'd1, 5'd3,  1'b0}, '{2'd1, 5'd4,  1'b1},
    '{2'd2, 5'd7,  1'b0}, '{2'd2, 5'd8,  1'b1},
    '{2'd3, 5'd13, 1'b0}, '{2'd3, 5'd14, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] d, input logic enh);
    ctl_wr = 1'b1; ctl_wdata = d; enh_en = enh;
    @(negedge clk);
    ctl_wr = 1'b0; enh_en = 1'b0;
  endtask

  task automatic rx_push(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      line_rx_valid = 1'b1; line_rx_data = base + 8'(i);
      @(negedge clk);
    end
    line_rx_valid = 1'b0;
  endtask

  task automatic tx_push(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      host_push = 1'b1; host_wdata = base + 8'(i);
      @(negedge clk);
    end
    host_push = 1'b0;
  endtask

  task automatic tx_pop(input int n);
    for (int i = 0; i < n; i++) begin
      line_tx_req = 1'b1;
      @(negedge clk);
    end
    line_tx_req = 1'b0;
  endtask

  task automatic rx_pop1();
    host_pop = 1'b1;
    @(negedge clk);
    host_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 rx_level", 32'(rx_level), 0);
    check("R11 tx_level", 32'(tx_level), 0);
    check("R11 ctl_rdata", 32'(ctl_rdata), 0);
    check("R11 tx_irq", 32'(tx_irq), 1);
    check("R11 rx_irq", 32'(rx_irq), 0);
    check("R11 ovf", 32'({tx_ovf, rx_ovf}), 0);

    // R8 receive threshold table
    foreach (VECS[k]) begin
      ctl_write({VECS[k].code, 2'b00, 1'b0, 2'b01, 1'b1}, 1'b0);
      rx_push(int'(VECS[k].n), 8'hA0);
      check("R8 rx_level", 32'(rx_level), 32'(VECS[k].n));
      check("R8 rx_irq", 32'(rx_irq), 32'(VECS[k].irq));
    end

    // R2 receive order (14 bytes A0.. in queue)
    for (int i = 0; i < 3; i++) begin
      rx_pop1();
      check("R2 rx order", 32'(host_rdata), 32'(8'hA0 + i));
    end
    check("R1 rx_level after pops", 32'(rx_level), 11);

    // R5 clear needs enable bit in the same write
    ctl_write(8'h02, 1'b0);
    check("R5 no clear without bit0", 32'(rx_level), 11);
    ctl_write(8'h03, 1'b0);
    check("R5 rx cleared", 32'(rx_level), 0);
    check("R5 rdata kept", 32'(host_rdata), 32'(8'hA2));

    // R4 pop from empty
    rx_pop1();
    check("R4 rdata held", 32'(host_rdata), 32'(8'hA2));
    check("R4 level stays 0", 32'(rx_level), 0);

    // R6 transmit clear
    tx_push(3, 8'h50);
    ctl_write(8'h04, 1'b0);
    check("R6 no clear without bit0", 32'(tx_level), 3);
    ctl_write(8'h05, 1'b0);
    check("R6 tx cleared", 32'(tx_level), 0);

    // R1/R3/R2 fill, overflow, order on transmit side
    tx_push(16, 8'h10);
    check("R1 tx full", 32'({tx_full, tx_empty}), 32'(2'b10));
    check("R1 tx_level 16", 32'(tx_level), 16);
    tx_push(1, 8'hEE);
    check("R3 ovf pulse", 32'(tx_ovf), 1);
    check("R3 level held", 32'(tx_level), 16);
    @(negedge clk);
    check("R3 ovf one cycle", 32'(tx_ovf), 0);
    for (int i = 0; i < 16; i++) begin
      tx_pop(1);
      check("R2 tx order", 32'(line_tx_data), 32'(8'h10 + i));
    end
    check("R1 tx empty", 32'({tx_full, tx_empty}), 32'(2'b01));

    // R10 transmit request, threshold 8 (code 10)
    ctl_write(8'h25, 1'b1);
    check("R9 tx code written", 32'(ctl_rdata[5:4]), 2);
    tx_push(5, 8'h30);
    check("R10 shallow fill quiet", 32'(tx_irq), 0);
    tx_pop(4);
    check("R10 shallow level1 quiet", 32'(tx_irq), 0);
    tx_pop(1);
    check("R10 empty requests", 32'(tx_irq), 1);
    tx_push(10, 8'h40);
    check("R10 deep fill quiet", 32'(tx_irq), 0);
    tx_pop(2);
    check("R10 at threshold quiet", 32'(tx_irq), 0);
    tx_pop(1);
    check("R10 below threshold requests", 32'(tx_irq), 1);

    // R9 locked without enhanced enable
    ctl_write(8'h35, 1'b0);
    check("R9 tx code kept", 32'(ctl_rdata), 32'(8'h21));

    // R7 read-back of all ones
    ctl_write(8'hFF, 1'b1);
    check("R7 read-back", 32'(ctl_rdata), 32'(8'hF9));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule